// File: doc/BRIEF.md
# Next-PC Selector with Exception Vectors

This block owns the program counter of a single-cycle processor and works out, every cycle, the address it will hold after the next rising clock edge. It chooses among seven sources: the sequential successor, a PC-relative branch target, a region-relative direct jump target, an indirect target taken from a register value, and three fixed vectors for reset, an illegal opcode and an interrupt. Instruction memory, the decoder and the register file stay outside. The decoder supplies the immediate, the jump field, the branch kind and the ALU zero flag. The register file supplies the indirect target.

When a trap is taken, the block raises a write request toward the register file. It presents the current PC plus four as the return address and names the reserved kernel register that receives it. The same return value serves the ordinary link-and-jump instructions, which the decoder routes itself.

Top module: `pc_sequencer`

## Requirements
- R1: `rstSync` is synchronous. A rising edge with it high loads 0x80000000 into `pcOut`, whatever the other inputs are, and `trapWrite` stays low while it is high.
- R2: With no reset, trap, jump or taken branch, the PC advances by 4 at each rising edge.
- R3: `brEq` is taken when `zeroFlag` is 1 and `brNe` is taken when `zeroFlag` is 0. A taken branch loads PC + 4 + 4 × sign-extended `immField`. A branch that is not taken advances by 4.
- R4: `jumpDirect` loads bits 31:28 of the current PC, then `jumpField` (26 bits), then two zero bits.
- R5: `jumpIndirect` loads `jumpReg` with its two low bits forced to zero.
- R6: `badOpcode` loads 0x80000040 and raises `trapWrite` in the same cycle as the flag.
- R7: `irqReq` loads 0x80000080 and raises `trapWrite` in the same cycle as the request.
- R8: Priority runs from highest to lowest: reset, bad opcode, interrupt, indirect jump, direct jump, taken branch, sequential.
- R9: `linkAddr` always equals `pcOut` + 4, and `trapLinkReg` always reads 27.
- R10: Bits 1:0 of `pcOut` are zero at all times after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rstSync | input | 1 | Synchronous reset, active high |
| irqReq | input | 1 | Interrupt request |
| badOpcode | input | 1 | Decoder found an illegal opcode |
| brEq | input | 1 | Current instruction is branch-if-equal |
| brNe | input | 1 | Current instruction is branch-if-not-equal |
| zeroFlag | input | 1 | ALU zero result of the operand subtraction |
| jumpDirect | input | 1 | Current instruction is a direct jump |
| jumpIndirect | input | 1 | Current instruction jumps through a register |
| jumpReg | input | 32 | Register value for the indirect target |
| jumpField | input | 26 | Jump target field of the instruction |
| immField | input | 16 | Branch offset in words, signed |
| pcOut | output | 32 | Current program counter |
| linkAddr | output | 32 | Current PC plus 4 (return address) |
| trapWrite | output | 1 | Request to write `linkAddr` into the kernel register |
| trapLinkReg | output | 5 | Index of the register that receives the trap return address |

## Verification
An interrupt or a bad opcode can arrive in the same cycle as a taken branch or a jump, and a bad opcode can coincide with an interrupt. The bench raises these inputs together on one cycle. It checks that the next PC is the vector of the stronger event, and that `trapWrite` and `linkAddr` show the trap's return address in that same cycle. Conflicts between jumps and branches are handled the same way: the loaded address must come from the stronger source.

// File: rtl/pcsel_pkg.sv
package pcsel_pkg;

  typedef enum logic [2:0] {
    SEL_SEQ      = 3'd0,
    SEL_BRANCH   = 3'd1,
    SEL_JUMP     = 3'd2,
    SEL_INDIRECT = 3'd3,
    SEL_RESET    = 3'd4,
    SEL_BADOP    = 3'd5,
    SEL_IRQ      = 3'd6
  } pcSel_e;

  typedef struct packed {
    pcSel_e sel;
    logic   trapWrite;
  } pcStrobes_t;

endpackage

// File: rtl/pc_ctrl.sv
module pc_ctrl
  import pcsel_pkg::*;
(
  input  logic       rstSync,
  input  logic       irqReq,
  input  logic       badOpcode,
  input  logic       brEq,
  input  logic       brNe,
  input  logic       zeroFlag,
  input  logic       jumpDirect,
  input  logic       jumpIndirect,
  output pcStrobes_t strobes
);

  logic branchTaken;

  always_comb begin
    branchTaken = (brEq && zeroFlag) || (brNe && !zeroFlag);
  end

  // Priority: reset, bad opcode, interrupt, indirect, direct, branch, sequential.
  always_comb begin
    strobes.sel       = SEL_SEQ;
    strobes.trapWrite = 1'b0;
    if (rstSync) begin
      strobes.sel = SEL_RESET;
    end else if (badOpcode) begin
      strobes.sel       = SEL_BADOP;
      strobes.trapWrite = 1'b1;
    end else if (irqReq) begin
      strobes.sel       = SEL_IRQ;
      strobes.trapWrite = 1'b1;
    end else if (jumpIndirect) begin
      strobes.sel = SEL_INDIRECT;
    end else if (jumpDirect) begin
      strobes.sel = SEL_JUMP;
    end else if (branchTaken) begin
      strobes.sel = SEL_BRANCH;
    end
  end

endmodule

// File: rtl/pc_targets.sv
module pc_targets #(
  parameter int ADDR_W = 32,
  parameter int JUMP_W = 26,
  parameter int IMM_W  = 16,
  localparam int HIGH_W = ADDR_W - JUMP_W - 2,
  localparam int EXT_W  = ADDR_W - IMM_W - 2
) (
  input  logic [HIGH_W-1:0] pcHigh,
  input  logic [ADDR_W-1:0] pcPlus4,
  input  logic [IMM_W-1:0]  immField,
  input  logic [JUMP_W-1:0] jumpField,
  input  logic [ADDR_W-1:0] jumpReg,
  output logic [ADDR_W-1:0] branchTarget,
  output logic [ADDR_W-1:0] jumpTarget,
  output logic [ADDR_W-1:0] indirectTarget
);

  logic [ADDR_W-1:0] byteOffset;

  always_comb begin
    // Word offset widened with its sign, then moved left by two bit places.
    byteOffset     = {{EXT_W{immField[IMM_W-1]}}, immField, 2'b00};
    branchTarget   = pcPlus4 + byteOffset;
    jumpTarget     = {pcHigh, jumpField, 2'b00};
    indirectTarget = jumpReg & ~ADDR_W'(3);
  end

endmodule

// File: rtl/pc_dpath.sv
module pc_dpath
  import pcsel_pkg::*;
#(
  parameter int              ADDR_W    = 32,
  parameter int              JUMP_W    = 26,
  parameter int              IMM_W     = 16,
  parameter logic [ADDR_W-1:0] RESET_VEC = 32'h8000_0000,
  parameter logic [ADDR_W-1:0] BADOP_VEC = 32'h8000_0040,
  parameter logic [ADDR_W-1:0] IRQ_VEC   = 32'h8000_0080,
  localparam int HIGH_W = ADDR_W - JUMP_W - 2
) (
  input  logic              clk,
  input  pcStrobes_t        strobes,
  input  logic [ADDR_W-1:0] jumpReg,
  input  logic [JUMP_W-1:0] jumpField,
  input  logic [IMM_W-1:0]  immField,
  output logic [ADDR_W-1:0] pcOut,
  output logic [ADDR_W-1:0] linkAddr
);

  logic [ADDR_W-1:0] pcQ;
  logic [ADDR_W-1:0] pcPlus4;
  logic [ADDR_W-1:0] pcNext;
  logic [ADDR_W-1:0] branchTarget;
  logic [ADDR_W-1:0] jumpTarget;
  logic [ADDR_W-1:0] indirectTarget;

  always_comb begin
    pcPlus4 = pcQ + ADDR_W'(4);
  end

  pc_targets #(
    .ADDR_W(ADDR_W),
    .JUMP_W(JUMP_W),
    .IMM_W (IMM_W)
  ) i_targets (
    .pcHigh        (pcQ[ADDR_W-1 -: HIGH_W]),
    .pcPlus4       (pcPlus4),
    .immField      (immField),
    .jumpField     (jumpField),
    .jumpReg       (jumpReg),
    .branchTarget  (branchTarget),
    .jumpTarget    (jumpTarget),
    .indirectTarget(indirectTarget)
  );

  // Seven-way next-PC mux.
  always_comb begin
    unique case (strobes.sel)
      SEL_RESET:    pcNext = RESET_VEC;
      SEL_BADOP:    pcNext = BADOP_VEC;
      SEL_IRQ:      pcNext = IRQ_VEC;
      SEL_INDIRECT: pcNext = indirectTarget;
      SEL_JUMP:     pcNext = jumpTarget;
      SEL_BRANCH:   pcNext = branchTarget;
      default:      pcNext = pcPlus4;
    endcase
  end

  always_ff @(posedge clk) begin
    pcQ <= pcNext;
  end

  always_comb begin
    pcOut    = pcQ;
    linkAddr = pcPlus4;
  end

endmodule

// File: rtl/pc_sequencer.sv
module pc_sequencer
  import pcsel_pkg::*;
#(
  parameter int              ADDR_W    = 32,
  parameter int              JUMP_W    = 26,
  parameter int              IMM_W     = 16,
  parameter int              REG_IDX_W = 5,
  parameter int              LINK_REG  = 27,
  parameter logic [ADDR_W-1:0] RESET_VEC = 32'h8000_0000,
  parameter logic [ADDR_W-1:0] BADOP_VEC = 32'h8000_0040,
  parameter logic [ADDR_W-1:0] IRQ_VEC   = 32'h8000_0080
) (
  input  logic                 clk,
  input  logic                 rstSync,
  input  logic                 irqReq,
  input  logic                 badOpcode,
  input  logic                 brEq,
  input  logic                 brNe,
  input  logic                 zeroFlag,
  input  logic                 jumpDirect,
  input  logic                 jumpIndirect,
  input  logic [ADDR_W-1:0]    jumpReg,
  input  logic [JUMP_W-1:0]    jumpField,
  input  logic [IMM_W-1:0]     immField,
  output logic [ADDR_W-1:0]    pcOut,
  output logic [ADDR_W-1:0]    linkAddr,
  output logic                 trapWrite,
  output logic [REG_IDX_W-1:0] trapLinkReg
);

  pcStrobes_t strobes;

  pc_ctrl i_ctrl (
    .rstSync     (rstSync),
    .irqReq      (irqReq),
    .badOpcode   (badOpcode),
    .brEq        (brEq),
    .brNe        (brNe),
    .zeroFlag    (zeroFlag),
    .jumpDirect  (jumpDirect),
    .jumpIndirect(jumpIndirect),
    .strobes     (strobes)
  );

  pc_dpath #(
    .ADDR_W   (ADDR_W),
    .JUMP_W   (JUMP_W),
    .IMM_W    (IMM_W),
    .RESET_VEC(RESET_VEC),
    .BADOP_VEC(BADOP_VEC),
    .IRQ_VEC  (IRQ_VEC)
  ) i_dpath (
    .clk      (clk),
    .strobes  (strobes),
    .jumpReg  (jumpReg),
    .jumpField(jumpField),
    .immField (immField),
    .pcOut    (pcOut),
    .linkAddr (linkAddr)
  );

  always_comb begin
    trapWrite   = strobes.trapWrite;
    trapLinkReg = REG_IDX_W'(LINK_REG);
  end

endmodule

// File: rtl/pc_sequencer_chk.sv
module pc_sequencer_chk #(
  parameter int              ADDR_W    = 32,
  parameter logic [ADDR_W-1:0] RESET_VEC = 32'h8000_0000,
  parameter logic [ADDR_W-1:0] BADOP_VEC = 32'h8000_0040,
  parameter logic [ADDR_W-1:0] IRQ_VEC   = 32'h8000_0080
) (
  input logic              clk,
  input logic              rstSync,
  input logic              irqReq,
  input logic              badOpcode,
  input logic              brEq,
  input logic              brNe,
  input logic              zeroFlag,
  input logic              jumpDirect,
  input logic              jumpIndirect,
  input logic [ADDR_W-1:0] pcOut,
  input logic [ADDR_W-1:0] linkAddr,
  input logic              trapWrite
);

  logic started = 1'b0;
  logic quiet;

  always_ff @(posedge clk) started <= 1'b1;

  always_comb begin
    quiet = !badOpcode && !irqReq && !jumpDirect && !jumpIndirect &&
            !(brEq && zeroFlag) && !(brNe && !zeroFlag);
  end

  AST_RESET_VECTOR: assert property (@(posedge clk) disable iff (!started)
    rstSync |=> pcOut == RESET_VEC); // R1
  AST_NO_TRAP_IN_RESET: assert property (@(posedge clk)
    rstSync |-> !trapWrite); // R1
  AST_SEQUENTIAL_STEP: assert property (@(posedge clk) disable iff (rstSync)
    quiet |=> pcOut == $past(pcOut) + ADDR_W'(4)); // R2
  AST_BADOP_VECTOR: assert property (@(posedge clk) disable iff (rstSync)
    badOpcode |=> pcOut == BADOP_VEC); // R6
  AST_BADOP_TRAP: assert property (@(posedge clk) disable iff (rstSync)
    badOpcode |-> trapWrite); // R6
  AST_IRQ_VECTOR: assert property (@(posedge clk) disable iff (rstSync)
    (irqReq && !badOpcode) |=> pcOut == IRQ_VEC); // R7
  AST_LINK_FOLLOWS_PC: assert property (@(posedge clk) disable iff (rstSync)
    linkAddr == pcOut + ADDR_W'(4)); // R9
  AST_PC_ALIGNED: assert property (@(posedge clk) disable iff (rstSync)
    pcOut[1:0] == 2'b00); // R10

endmodule

bind pc_sequencer pc_sequencer_chk #(
  .ADDR_W   (ADDR_W),
  .RESET_VEC(RESET_VEC),
  .BADOP_VEC(BADOP_VEC),
  .IRQ_VEC  (IRQ_VEC)
) i_pc_sequencer_chk (
  .clk         (clk),
  .rstSync     (rstSync),
  .irqReq      (irqReq),
  .badOpcode   (badOpcode),
  .brEq        (brEq),
  .brNe        (brNe),
  .zeroFlag    (zeroFlag),
  .jumpDirect  (jumpDirect),
  .jumpIndirect(jumpIndirect),
  .pcOut       (pcOut),
  .linkAddr    (linkAddr),
  .trapWrite   (trapWrite)
);

// File: tb/test_pc_sequencer.sv
module test_pc_sequencer;

  logic        clk = 1'b0;
  logic        rstSync, irqReq, badOpcode, brEq, brNe, zeroFlag;
  logic        jumpDirect, jumpIndirect;
  logic [31:0] jumpReg;
  logic [25:0] jumpField;
  logic [15:0] immField;
  logic [31:0] pcOut, linkAddr;
  logic        trapWrite;
  logic [4:0]  trapLinkReg;

  int errors = 0;
  int checks = 0;
  bit done   = 0;

  always #10 clk = ~clk;  // 50 MHz

  pc_sequencer i_pc_sequencer (
    .clk(clk), .rstSync(rstSync), .irqReq(irqReq), .badOpcode(badOpcode),
    .brEq(brEq), .brNe(brNe), .zeroFlag(zeroFlag), .jumpDirect(jumpDirect),
    .jumpIndirect(jumpIndirect), .jumpReg(jumpReg), .jumpField(jumpField),
    .immField(immField), .pcOut(pcOut), .linkAddr(linkAddr),
    .trapWrite(trapWrite), .trapLinkReg(trapLinkReg)
  );

  typedef struct packed {
    logic        irq, bad, beq, bne, z, jd, ji;
    logic [31:0] jreg;
    logic [25:0] jfld;
    logic [15:0] imm;
    logic [31:0] expPc;
    logic        expTrap;
  } vec_t;

  localparam int NVEC = 16;
  localparam vec_t VECS [NVEC] = '{
    '{0,0,0,0,0,0,0, 32'h0,        26'h0,       16'h0,    32'h8000_0004, 1'b0}, // R2
    '{0,0,1,0,1,0,0, 32'h0,        26'h0,       16'h0010, 32'h8000_0048, 1'b0}, // R3 beq taken
    '{0,0,1,0,0,0,0, 32'h0,        26'h0,       16'h0010, 32'h8000_004C, 1'b0}, // R3 beq not taken
    '{0,0,0,1,0,0,0, 32'h0,        26'h0,       16'hFFFE, 32'h8000_0048, 1'b0}, // R3 bne back
    '{0,0,0,1,1,0,0, 32'h0,        26'h0,       16'hFFFE, 32'h8000_004C, 1'b0}, // R3 bne not taken
    '{0,0,0,0,0,1,0, 32'h0,        26'h100,     16'h0,    32'h8000_0400, 1'b0}, // R4
    '{0,0,0,0,0,0,1, 32'h0000_1233,26'h0,       16'h0,    32'h0000_1230, 1'b0}, // R5
    '{0,0,0,0,0,0,0, 32'h0,        26'h0,       16'h0,    32'h0000_1234, 1'b0}, // R2
    '{0,0,0,0,0,1,0, 32'h0,        26'h3FF_FFFF,16'h0,    32'h0FFF_FFFC, 1'b0}, // R4 full field
    '{0,0,0,0,0,0,0, 32'h0,        26'h0,       16'h0,    32'h1000_0000, 1'b0}, // R2 region carry
    '{1,0,0,0,0,0,0, 32'h0,        26'h0,       16'h0,    32'h8000_0080, 1'b1}, // R7
    '{1,1,0,0,0,0,0, 32'h0,        26'h0,       16'h0,    32'h8000_0040, 1'b1}, // R6 over irq
    '{0,0,1,0,1,0,0, 32'h0,        26'h0,       16'h8000, 32'h7FFE_0044, 1'b0}, // R3 most negative
    '{1,0,0,0,0,0,1, 32'h0000_0100,26'h0,       16'h0,    32'h8000_0080, 1'b1}, // R8 irq over jr
    '{0,0,0,0,0,1,1, 32'h0040_0000,26'h5,       16'h0,    32'h0040_0000, 1'b0}, // R8 jr over j
    '{0,0,1,0,1,1,0, 32'h0,        26'h10,      16'h0004, 32'h0000_0040, 1'b0}  // R8 j over branch
  };

  function automatic string tagOf(vec_t v);
    int n = int'(v.irq) + int'(v.bad) + int'(v.jd) + int'(v.ji) +
            int'(v.beq || v.bne);
    if (n > 1)  return "R8";
    if (v.bad)  return "R6";
    if (v.irq)  return "R7";
    if (v.ji)   return "R5";
    if (v.jd)   return "R4";
    if (v.beq || v.bne) return "R3";
    return "R2";
  endfunction

  task automatic check32(string tag, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic idle();
    irqReq = 0; badOpcode = 0; brEq = 0; brNe = 0; zeroFlag = 0;
    jumpDirect = 0; jumpIndirect = 0; jumpReg = '0; jumpField = '0; immField = '0;
  endtask

  initial begin : watchdog
    repeat (5000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin : stim
    logic [31:0] prevPc;
    idle();
    rstSync = 1; irqReq = 1; badOpcode = 1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check32("R1", "pc after reset", pcOut, 32'h8000_0000);
    check32("R1", "no trap in reset", {31'b0, trapWrite}, 32'h0);
    rstSync = 0; idle();
    check32("R9", "link register index", {27'b0, trapLinkReg}, 32'd27);
    prevPc = 32'h8000_0000;

    for (int i = 0; i < NVEC; i++) begin
      irqReq = VECS[i].irq; badOpcode = VECS[i].bad; brEq = VECS[i].beq;
      brNe = VECS[i].bne; zeroFlag = VECS[i].z; jumpDirect = VECS[i].jd;
      jumpIndirect = VECS[i].ji; jumpReg = VECS[i].jreg;
      jumpField = VECS[i].jfld; immField = VECS[i].imm;
      #1;
      check32("R9", "link before edge", linkAddr, prevPc + 32'd4);
      check32(tagOf(VECS[i]), "trap strobe", {31'b0, trapWrite}, {31'b0, VECS[i].expTrap});
      @(negedge clk);
      check32(tagOf(VECS[i]), "next pc", pcOut, VECS[i].expPc);
      check32("R10", "alignment", {30'b0, pcOut[1:0]}, 32'h0);
      prevPc = VECS[i].expPc;
    end

    // R1, R8: reset beats every other request in mid-run.
    idle();
    rstSync = 1; badOpcode = 1; irqReq = 1; jumpIndirect = 1; jumpReg = 32'h1234_5678;
    #1;
    check32("R1", "trap held off in reset", {31'b0, trapWrite}, 32'h0);
    @(negedge clk);
    check32("R1", "reset over all", pcOut, 32'h8000_0000);
    rstSync = 0; idle();

    // R2: a run of plain steps.
    repeat (3) @(negedge clk);
    check32("R2", "three steps", pcOut, 32'h8000_000C);

    // R3: both branch kinds raised, zero=1 -> beq taken.
    brEq = 1; brNe = 1; zeroFlag = 1; immField = 16'h0001;
    @(negedge clk);
    check32("R3", "dual branch flags", pcOut, 32'h8000_0014);
    idle();

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule